// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the host side of a link to an 8-channel, 10-bit serial converter that is clocked by the host. It drives chip select, the serial clock and the serial command line, and it samples the converter's serial data line. Each request carries a channel number, a polarity flag, an input-configuration flag and a two-bit power-down code. From these the sequencer builds an 8-bit command word, shifts it out, and collects the 10-bit conversion result. The result leaves on a valid/ready port with the channel number of the command that produced it.

Three framing modes are available. The single mode uses 24 clocks per conversion and raises chip select after each one. The two overlapped modes start the next command while the previous result is still arriving, and give one conversion every 16 or every 15 clocks. The serial clock comes from a programmable half-period divider. Settings outside the converter's 100 kHz to 2 MHz clock range are refused. After reset, the first frame is preceded by 16 zero bits so that the converter finds the first start bit.

Top module: `sadc_host_seq`

## Requirements
- R1: The command word is sent most significant bit first as {1, chan[2:0], unipolar, single_ended, pd[1:0]}. Every bit after the eighth command bit of a frame is 0.
- R2: `din` changes only on the falling serial-clock edge and never while `sclk` is high. `sclk` is low whenever `cs_n` is high. `dout` is sampled on the rising serial-clock edge.
- R3: In single mode (`frame_mode` = 0) a frame lasts exactly 24 serial-clock cycles, counted from the start bit, and then `cs_n` rises.
- R4: The result bits are the 10 bits sampled in serial-clock cycles 9 to 18 of a frame (1-based, start bit in cycle 1), first bit most significant. The two bits that follow are discarded. The result is reported with the channel of its command.
- R5: In 15-clock mode (`frame_mode` = 2), when a request is waiting, the next start bit is sent in cycle 16 of the current frame, right after the cycle in which the fourth-lowest result bit is sampled.
- R6: In 16-clock mode (`frame_mode` = 1), when a request is waiting, the next start bit is sent in cycle 17 of the current frame, after one extra zero cycle.
- R7: In the overlapped modes, each result carries the channel of the command that produced it, not the channel of the command being sent at that time.
- R8: In an overlapped mode, when no request is waiting at the point where the next start bit would go, `din` stays 0, the frame runs through cycle 18, and then `cs_n` rises.
- R9: The first frame after reset is preceded by exactly 16 zero bits with `cs_n` low.
- R10: A serial-clock half period lasts `half_div` system clocks. While `half_div` gives a serial clock below 100 kHz or above 2 MHz at `CLK_HZ`, no request is accepted and `cs_n` stays high.
- R11: While `res_valid` is high and `res_ready` is low, the result and its channel are held and `sclk` does not toggle.
- R12: After reset `cs_n` is high, `sclk`, `din` and `res_valid` are low, and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | Serial-clock half period in system clocks |
| frame_mode | input | 2 | 0 single 24-clock, 1 overlapped 16-clock, 2 overlapped 15-clock, 3 single |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_chan | input | 3 | Channel number |
| req_unipolar | input | 1 | 1 selects unipolar coding |
| req_single | input | 1 | 1 selects single-ended input |
| req_pd | input | 2 | Power-down code |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| din | output | 1 | Command bits to the converter |
| dout | input | 1 | Result bits from the converter |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken when high with res_valid |
| res_data | output | RES_W | Conversion result |
| res_chan | output | 3 | Channel of the command that produced the result |

## Verification
A wrong bit position shows up within one conversion. The bench's converter model then sees a start bit in the wrong cycle or decodes a different command word, and the measured start-to-start spacing, or the frame length before chip select rises, no longer matches the mode. A stale channel register gives a mismatched tag on the very next overlapped result. A shifted result capture window corrupts every returned value at once. A divider or stall fault changes the measured half period, or lets the clock move while a result is still held.

// File: rtl/sadc_host_seq.sv
module sadc_host_seq #(
  parameter int CLK_HZ      = 8_000_000,
  parameter int SCLK_MAX_HZ = 2_000_000,
  parameter int SCLK_MIN_HZ = 100_000,
  parameter int DIV_W       = 8,
  parameter int RES_W       = 10,
  parameter int PRE_BITS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic [1:0]       frame_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_chan,
  input  logic             req_unipolar,
  input  logic             req_single,
  input  logic [1:0]       req_pd,
  output logic             cs_n,
  output logic             sclk,
  output logic             din,
  input  logic             dout,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data,
  output logic [2:0]       res_chan
);

  localparam int CTL_W    = 8;
  localparam int SGL_LEN  = 24;
  localparam int PW       = $clog2(SGL_LEN + 1);
  localparam int PCW      = $clog2(PRE_BITS);
  localparam int HMIN     = (CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
  localparam int HMAX     = CLK_HZ / (2*SCLK_MIN_HZ);
  localparam logic [DIV_W-1:0] HMIN_V = DIV_W'(HMIN);
  localparam logic [DIV_W-1:0] HMAX_V = DIV_W'(HMAX);
  localparam logic [PW-1:0] RX_FIRST = PW'(CTL_W);
  localparam logic [PW-1:0] RX_LAST  = PW'(CTL_W + RES_W - 1);
  localparam logic [PW-1:0] SGL_END  = PW'(SGL_LEN - 1);
  localparam logic [PW-1:0] P15      = PW'(15);
  localparam logic [PW-1:0] P16      = PW'(16);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_RUN} st_t;

  st_t              st;
  logic [DIV_W-1:0] dcnt;
  logic [PW-1:0]    tp;
  logic [PCW-1:0]   pcnt;
  logic [CTL_W-1:0] ctl_sh;
  logic [RES_W-2:0] rx_sh;
  logic [2:0]       cur_chan, old_chan;
  logic             carry, pre_done;

  wire ovl       = (frame_mode == 2'd1) || (frame_mode == 2'd2);
  wire [PW-1:0] per   = (frame_mode == 2'd1) ? P16 : P15;
  wire [PW-1:0] last  = ovl ? RX_LAST : SGL_END;
  wire [PW-1:0] oidx  = tp + per;
  wire cfg_ok    = (half_div >= HMIN_V) && (half_div <= HMAX_V);
  wire stall     = res_valid && !res_ready;
  wire tick      = (st != S_IDLE) && !stall && (dcnt == half_div - DIV_W'(1));
  wire rise      = tick && !sclk;
  wire fall      = tick && sclk;
  wire at_seam   = (st == S_RUN) && ovl && (tp == per - PW'(1));
  wire pre_end   = (st == S_PRE) && (pcnt == PCW'(PRE_BITS - 1));
  wire run_rise  = rise && (st == S_RUN);
  wire cap       = run_rise && ((tp >= RX_FIRST && tp <= RX_LAST) || (carry && oidx <= RX_LAST));
  wire done_own  = run_rise && (tp == RX_LAST);
  wire done_old  = run_rise && carry && (oidx == RX_LAST);
  wire [CTL_W-1:0] new_ctl = {1'b1, req_chan, req_unipolar, req_single, req_pd};

  assign req_ready = cfg_ok && (((st == S_IDLE) && pre_done) || (fall && (pre_end || at_seam)));
  assign din       = ctl_sh[CTL_W-1];
  wire   take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_n <= 1'b1; sclk <= 1'b0; dcnt <= '0; tp <= '0; pcnt <= '0;
      ctl_sh <= '0; rx_sh <= '0; cur_chan <= '0; old_chan <= '0; carry <= 1'b0;
      pre_done <= 1'b0; res_valid <= 1'b0; res_data <= '0; res_chan <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (st == S_IDLE || tick) dcnt <= '0;
      else if (!stall)          dcnt <= dcnt + DIV_W'(1);
      if (cap) rx_sh <= {rx_sh[RES_W-3:0], dout};
      if (done_own || done_old) begin
        res_valid <= 1'b1;
        res_data  <= {rx_sh, dout};
        res_chan  <= done_old ? old_chan : cur_chan;
      end
      if (done_old) carry <= 1'b0;
      if (rise) sclk <= 1'b1;
      case (st)
        S_IDLE: if (cfg_ok && req_valid) begin
          cs_n <= 1'b0;
          if (pre_done) begin
            st <= S_RUN; tp <= '0; ctl_sh <= new_ctl; cur_chan <= req_chan; carry <= 1'b0;
          end else begin
            st <= S_PRE; pcnt <= '0;
          end
        end
        S_PRE: if (fall) begin
          sclk <= 1'b0;
          if (pre_end) begin
            pre_done <= 1'b1;
            if (take) begin
              st <= S_RUN; tp <= '0; ctl_sh <= new_ctl; cur_chan <= req_chan; carry <= 1'b0;
            end else begin
              st <= S_IDLE; cs_n <= 1'b1;
            end
          end else pcnt <= pcnt + PCW'(1);
        end
        S_RUN: if (fall) begin
          sclk <= 1'b0;
          if (take) begin
            tp <= '0; ctl_sh <= new_ctl; old_chan <= cur_chan; cur_chan <= req_chan; carry <= 1'b1;
          end else if (tp == last) begin
            st <= S_IDLE; cs_n <= 1'b1; ctl_sh <= '0;
          end else begin
            tp <= tp + PW'(1); ctl_sh <= {ctl_sh[CTL_W-2:0], 1'b0};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R2
  AST_DIN_STEADY_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(din)); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan))); // R11
  AST_CLOCK_FROZEN_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> $stable(sclk)); // R11
  AST_BAD_DIVIDER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (half_div < HMIN_V || half_div > HMAX_V) |-> !req_ready); // R10
  AST_SEAM_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !cs_n) |-> sclk); // R5

endmodule

// File: tb/sadc_host_seq_bench.sv
module sadc_host_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] half_div = 8'd3;
  logic [1:0] frame_mode = 2'd0;
  logic req_valid = 1'b0, req_unipolar = 1'b0, req_single = 1'b0, res_ready = 1'b1;
  logic [2:0] req_chan = '0;
  logic [1:0] req_pd = '0;
  logic dout = 1'b0;
  logic req_ready, cs_n, sclk, din, res_valid;
  logic [9:0] res_data;
  logic [2:0] res_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_host_seq u_sadc_host_seq (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .frame_mode(frame_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_unipolar(req_unipolar), .req_single(req_single), .req_pd(req_pd),
    .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_chan(res_chan));

  int total = 0, passed = 0, drv_n = 0, dev_n = 0;
  logic [12:0] exp_q[$];
  logic [7:0]  ctl_q[$];
  string tag_tag = "R4", per_tag = "R5", tail_tag = "R3";
  int exp_period = 0, exp_tail = 24;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  endtask

  function automatic logic [9:0] conv_val(int n, logic [2:0] ch, logic u, logic s, logic [1:0] pd);
    return 10'((int'(ch)*101 + int'(u)*37 + int'(s)*53 + int'(pd)*7 + n*29 + 3) % 1024);
  endfunction

  // converter model
  int win_rises = 0, last_start = -1, nbits = 0, out_idx = 0;
  bit collecting = 0, conv_go = 0, out_act = 0, pre_checked = 0;
  logic [7:0] cbyte, ctl_exp;
  logic [9:0] cur_val;
  logic [11:0] out_word;

  always @(negedge cs_n) begin win_rises = 0; last_start = -1; end

  always @(posedge sclk) if (!cs_n) begin
    win_rises++;
    if (collecting) begin
      cbyte = {cbyte[6:0], din}; nbits++;
      if (nbits == 8) begin
        collecting = 0; conv_go = 1;
        if (ctl_q.size() > 0) begin ctl_exp = ctl_q.pop_front(); chk(cbyte == ctl_exp, "R1", cbyte, ctl_exp); end
        else chk(0, "R1", cbyte, 0);
        cur_val = conv_val(dev_n, cbyte[6:4], cbyte[3], cbyte[2], cbyte[1:0]); dev_n++;
      end
    end else if (din && (!out_act || out_idx >= 6)) begin
      collecting = 1; nbits = 1; cbyte = 8'h01;
      if (last_start >= 0 && exp_period > 0) chk(win_rises - last_start == exp_period, per_tag, win_rises - last_start, exp_period);
      if (!pre_checked) begin pre_checked = 1; chk(win_rises - 1 == 16, "R9", win_rises - 1, 16); end
      last_start = win_rises;
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    if (conv_go) begin
      conv_go = 0; out_act = 1; out_idx = 0; out_word = {cur_val, 2'b11}; dout = out_word[11];
    end else if (out_act) begin
      if (out_idx < 20) out_idx++;
      dout = (out_idx < 12) ? out_word[11 - out_idx] : 1'b0;
    end
  end

  always @(posedge cs_n) begin
    if (last_start >= 0) chk(win_rises - last_start + 1 == exp_tail, tail_tag, win_rises - last_start + 1, exp_tail);
    last_start = -1; collecting = 0; out_act = 0; conv_go = 0; dout = 1'b0; out_idx = 0;
  end

  // line monitors
  logic prev_din = 1'b0;
  int viol = 0, hi_run = 0, last_hi = 0;
  always @(negedge clk) if (rst_n) begin
    if (din != prev_din && sclk) viol++;
    if (cs_n && sclk) viol++;
    prev_din = din;
    if (sclk) hi_run++;
    else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
  end

  // scoreboard monitor
  logic [12:0] item;
  always @(negedge clk) if (rst_n && res_valid && res_ready) begin
    if (exp_q.size() == 0) chk(0, "R4", res_data, 0);
    else begin
      item = exp_q.pop_front();
      chk(res_data == item[9:0], "R4", res_data, item[9:0]);
      chk(res_chan == item[12:10], tag_tag, res_chan, item[12:10]);
    end
  end

  task automatic send(input logic [2:0] ch, input logic u, input logic s, input logic [1:0] pd);
    @(negedge clk);
    req_chan = ch; req_unipolar = u; req_single = s; req_pd = pd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({ch, conv_val(drv_n, ch, u, s, pd)});
    ctl_q.push_back({1'b1, ch, u, s, pd});
    drv_n++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !din && !res_valid && !req_ready, "R12", {cs_n, sclk, din, res_valid, req_ready}, 5'b10000);

    // R10: out-of-range dividers are refused
    begin
      bit seen = 0;
      half_div = 8'd1; req_valid = 1'b1; req_chan = 3'd2;
      repeat (60) begin @(negedge clk); if (req_ready || !cs_n) seen = 1; end
      chk(!seen, "R10", seen, 0);
      seen = 0; half_div = 8'd41;
      repeat (60) begin @(negedge clk); if (req_ready || !cs_n) seen = 1; end
      chk(!seen, "R10", seen, 0);
      req_valid = 1'b0; half_div = 8'd3;
      @(negedge clk);
    end

    // single 24-clock frames (R3, R4, R9)
    frame_mode = 2'd0; exp_period = 0; exp_tail = 24; tail_tag = "R3"; tag_tag = "R4";
    send(3'd3, 1'b1, 1'b1, 2'b00);
    send(3'd5, 1'b0, 1'b0, 2'b01);
    drain();
    chk(last_hi == 3, "R10", last_hi, 3);

    // overlapped 16-clock (R6, R7, R8)
    frame_mode = 2'd1; exp_period = 16; per_tag = "R6"; exp_tail = 18; tail_tag = "R8"; tag_tag = "R7";
    send(3'd1, 1'b1, 1'b0, 2'b11);
    send(3'd6, 1'b0, 1'b1, 2'b10);
    send(3'd7, 1'b1, 1'b1, 2'b01);
    send(3'd0, 1'b0, 1'b0, 2'b00);
    drain();

    // overlapped 15-clock (R5, R7, R8)
    frame_mode = 2'd2; exp_period = 15; per_tag = "R5";
    send(3'd4, 1'b0, 1'b1, 2'b01);
    send(3'd2, 1'b1, 1'b0, 2'b11);
    send(3'd7, 1'b0, 1'b0, 2'b10);
    send(3'd1, 1'b1, 1'b1, 2'b00);
    drain();

    // result stall (R11)
    frame_mode = 2'd0; exp_period = 0; exp_tail = 24; tail_tag = "R3"; tag_tag = "R4";
    res_ready = 1'b0;
    send(3'd6, 1'b1, 1'b0, 2'b10);
    begin
      int waitc = 0, toggles = 0;
      logic s0;
      logic [9:0] d0;
      logic [2:0] c0;
      while (!res_valid && waitc < 2000) begin @(negedge clk); waitc++; end
      s0 = sclk; d0 = res_data; c0 = res_chan;
      repeat (40) begin @(negedge clk); if (sclk != s0) toggles++; end
      chk(toggles == 0, "R11", toggles, 0);
      chk(res_valid && res_data == d0 && res_chan == c0, "R11", res_data, d0);
      res_ready = 1'b1;
    end
    drain();

    chk(viol == 0, "R2", viol, 0);
    chk(exp_q.size() == 0 && ctl_q.size() == 0, "R1", ctl_q.size(), 0);
    finish_run();
  end
endmodule